// File: doc/BRIEF.md
# Partitioned SIMD Fixed-Point ALU

This block is a registered 64-bit datapath that treats each operand as a row of packed signed fixed-point lanes. It adds or subtracts lane by lane with every carry cut at the lane edges. It applies any of the sixteen two-input Boolean functions bit by bit. It also compares lanes, and a compare returns one mask bit per lane instead of condition flags. A lane-size select picks narrow lanes (four 16-bit lanes by default) or wide lanes (two 32-bit lanes). A single-width select restricts the operation to the low half of the word.

An operation is issued by raising `in_valid` with the operands, opcode and selects. The result and mask register on the next rising clock edge, and `out_valid` rises in the same cycle. While `in_valid` is low, the output registers hold their values. The opcode is a 5-bit field. Code `00000` is add and `00001` is subtract. Codes `00100`, `00101`, `00110` and `00111` are the compares greater-than, less-or-equal, not-equal and equal. Codes `1tttt` are the logical group, whose low four bits form a truth table. All other codes are reserved.

Top module: `simd_fixed_alu`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result`, `cmp_mask` and `out_valid` become zero on that edge.
- R2: `out_valid` equals the `in_valid` sampled at the previous rising edge. An issued operation shows its `result` and `cmp_mask` after exactly one edge. When `in_valid` is low, both outputs keep their values.
- R3: Opcode `00000` adds each lane of `src_a` to the same lane of `src_b`, modulo 2^lane-width. Lanes are NARROW_W bits wide when `wide_lanes`=0 and WIDE_W bits wide when `wide_lanes`=1, with lane 0 in the least significant bits. No carry passes from one lane into the next.
- R4: Opcode `00001` computes `src_a` minus `src_b` for each lane, modulo 2^lane-width, and no borrow crosses a lane edge.
- R5: For opcode `1tttt`, result bit i equals truth-table bit t[2*a_i + b_i], where a_i and b_i are bit i of `src_a` and `src_b`. For example, `11000` is AND, `11110` is OR, `10110` is XOR, `11100` copies `src_a`, `10000` gives zero and `11111` gives all ones.
- R6: A compare treats the lanes as two's-complement signed values. It sets `cmp_mask` bit k when the relation holds for lane k, with lane 0 in bit 0. Mask bits above the last active lane are zero, and `result` is zero.
- R7: With `single_w`=1, only the lanes in the low DATA_W/2 bits take part. The upper half of `result` is zero, and no mask bit is set for a lane in the upper half.
- R8: An opcode that is not a compare leaves `cmp_mask` at zero.
- R9: A reserved opcode (`00010`, `00011` or `01xxx`) gives zero in both `result` and `cmp_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Issue strobe for the operation presented this cycle |
| opcode | input | 5 | Operation code (see R3 to R9) |
| wide_lanes | input | 1 | 0: NARROW_W lanes, 1: WIDE_W lanes |
| single_w | input | 1 | 1: operate on the low DATA_W/2 bits only |
| src_a | input | DATA_W | First operand |
| src_b | input | DATA_W | Second operand |
| out_valid | output | 1 | Result and mask belong to an operation issued one edge earlier |
| result | output | DATA_W | Lane-wise or bitwise result |
| cmp_mask | output | MASK_W | Per-lane compare bits, lane 0 in bit 0 |

## Verification
The bench builds the unit with DATA_W=16, NARROW_W=4, WIDE_W=8 and MASK_W=8. This keeps the shape of the full-size unit: four narrow lanes, two wide lanes and a half-width mode. With a 4-bit narrow lane, every pair of lane values can be broadcast across all lanes for add, subtract and the four compares, in both full and single width. That sweep reaches every wrap, every sign boundary and every carry that would leak into a neighbouring lane. Wide lanes, all sixteen truth tables and the reserved codes are covered by pseudo-random operands against an arithmetic model in the bench.

// File: rtl/simd_alu_pkg.sv
// Package: shared opcode type, opcode constants and decode helpers for the
// partitioned SIMD fixed-point ALU.
// Assumes a 5-bit opcode. Codes 1tttt form the logical group, where tttt is a
// truth table indexed by {a_bit, b_bit}.
package simd_alu_pkg;

    localparam int OPC_W = 5;

    typedef logic [OPC_W-1:0] opcode_t;

    localparam opcode_t OPC_ADD    = 5'b00000;
    localparam opcode_t OPC_SUB    = 5'b00001;
    localparam opcode_t OPC_CMPGT  = 5'b00100;
    localparam opcode_t OPC_CMPLE  = 5'b00101;
    localparam opcode_t OPC_CMPNE  = 5'b00110;
    localparam opcode_t OPC_CMPEQ  = 5'b00111;

    typedef enum logic [1:0] {
        REL_GT = 2'd0,
        REL_LE = 2'd1,
        REL_NE = 2'd2,
        REL_EQ = 2'd3
    } relation_t;

    // Lane add or subtract group
    function automatic logic opc_is_arith(opcode_t o);
        return o[4:1] == 4'b0000;
    endfunction

    // Lane compare group
    function automatic logic opc_is_cmp(opcode_t o);
        return o[4:2] == 3'b001;
    endfunction

    // Bitwise logical group
    function automatic logic opc_is_bool(opcode_t o);
        return o[4];
    endfunction

endpackage

// File: rtl/simd_lane_addsub.sv
// Module: lane-partitioned adder/subtractor.
// Splits DATA_W into DATA_W/LANE_W independent lanes. Each lane computes
// a + b or a - b modulo 2^LANE_W, and no carry crosses a lane boundary.
// Assumes LANE_W divides DATA_W. The logic is purely combinational.
module simd_lane_addsub #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 16
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              do_sub,
    output logic [DATA_W-1:0] sum
);
    localparam int LANES = DATA_W / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] a_l;
        logic [LANE_W-1:0] b_l;
        logic [LANE_W-1:0] b_eff;

        // Select the lane slices and invert b for subtraction
        always_comb begin
            a_l   = op_a[g*LANE_W +: LANE_W];
            b_l   = op_b[g*LANE_W +: LANE_W];
            b_eff = b_l ^ {LANE_W{do_sub}};
        end

        // Lane-local adder; the carry-in is the subtract flag and the carry-out is dropped
        assign sum[g*LANE_W +: LANE_W] = a_l + b_eff + LANE_W'(do_sub);
    end

endmodule

// File: rtl/simd_lane_cmp.sv
// Module: lane-partitioned signed comparator.
// For each of the DATA_W/LANE_W lanes it reports signed greater-than and
// equality. The caller derives less-or-equal and not-equal from these.
// Assumes LANE_W divides DATA_W. The logic is purely combinational.
module simd_lane_cmp #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 16,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [LANES-1:0]  gt,
    output logic [LANES-1:0]  eq
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [LANE_W-1:0] a_s;
        logic signed [LANE_W-1:0] b_s;

        // Interpret the lane slices as two's-complement values
        always_comb begin
            a_s = op_a[g*LANE_W +: LANE_W];
            b_s = op_b[g*LANE_W +: LANE_W];
        end

        // Signed relations for this lane
        assign gt[g] = a_s > b_s;
        assign eq[g] = a_s == b_s;
    end

endmodule

// File: rtl/simd_bool_unit.sv
// Module: bitwise two-input Boolean function generator.
// Each result bit picks one entry of a 4-entry truth table, addressed by
// {a_bit, b_bit}, so all sixteen two-input functions share one mux per bit.
// The logic is purely combinational.
module simd_bool_unit #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [3:0]        truth,
    output logic [DATA_W-1:0] res
);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        // Truth-table lookup for bit i
        assign res[i] = truth[{op_a[i], op_b[i]}];
    end

endmodule

// File: rtl/simd_fixed_alu.sv
// Module: partitioned SIMD fixed-point ALU, the top of the block.
// Lane add/subtract, the sixteen bitwise functions and per-lane signed
// compares on packed operands. The results register one edge after issue.
// Assumes that NARROW_W and WIDE_W both divide DATA_W, that DATA_W/NARROW_W
// lanes fit in MASK_W, and that each lane width divides DATA_W/2. Reset is
// synchronous and active low.
module simd_fixed_alu
    import simd_alu_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32,
    parameter int MASK_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [4:0]        opcode,
    input  logic              wide_lanes,
    input  logic              single_w,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [MASK_W-1:0] cmp_mask
);
    localparam int HALF_W      = DATA_W / 2;
    localparam int NARROW_LN   = DATA_W / NARROW_W;
    localparam int WIDE_LN     = DATA_W / WIDE_W;
    localparam int NARROW_HALF = NARROW_LN / 2;

    logic [DATA_W-1:0]    sum_n, sum_w, bool_res;
    logic [NARROW_LN-1:0] gt_n, eq_n;
    logic [WIDE_LN-1:0]   gt_w, eq_w;
    logic [DATA_W-1:0]    nxt_res;
    logic [MASK_W-1:0]    nxt_mask;
    logic [MASK_W-1:0]    rel_mask;
    relation_t            rel;

    simd_lane_addsub #(.DATA_W(DATA_W), .LANE_W(NARROW_W)) u_add_n (
        .op_a(src_a), .op_b(src_b), .do_sub(opcode[0]), .sum(sum_n)
    );
    simd_lane_addsub #(.DATA_W(DATA_W), .LANE_W(WIDE_W)) u_add_w (
        .op_a(src_a), .op_b(src_b), .do_sub(opcode[0]), .sum(sum_w)
    );
    simd_lane_cmp #(.DATA_W(DATA_W), .LANE_W(NARROW_W)) u_cmp_n (
        .op_a(src_a), .op_b(src_b), .gt(gt_n), .eq(eq_n)
    );
    simd_lane_cmp #(.DATA_W(DATA_W), .LANE_W(WIDE_W)) u_cmp_w (
        .op_a(src_a), .op_b(src_b), .gt(gt_w), .eq(eq_w)
    );
    simd_bool_unit #(.DATA_W(DATA_W)) u_bool (
        .op_a(src_a), .op_b(src_b), .truth(opcode[3:0]), .res(bool_res)
    );

    assign rel = relation_t'(opcode[1:0]);

    // Turn the lane relations of the selected width into a zero-extended mask
    always_comb begin
        rel_mask = '0;
        if (wide_lanes) begin
            case (rel)
                REL_GT:  rel_mask = MASK_W'(gt_w);
                REL_LE:  rel_mask = MASK_W'(~gt_w);
                REL_NE:  rel_mask = MASK_W'(~eq_w);
                default: rel_mask = MASK_W'(eq_w);
            endcase
        end else begin
            case (rel)
                REL_GT:  rel_mask = MASK_W'(gt_n);
                REL_LE:  rel_mask = MASK_W'(~gt_n);
                REL_NE:  rel_mask = MASK_W'(~eq_n);
                default: rel_mask = MASK_W'(eq_n);
            endcase
        end
    end

    // Choose the group output, then trim it to the low half in single-width mode
    always_comb begin
        int active;
        nxt_res  = '0;
        nxt_mask = '0;
        active   = wide_lanes ? WIDE_LN : NARROW_LN;
        if (single_w) begin
            active = active / 2;
        end
        if (opc_is_arith(opcode)) begin
            nxt_res = wide_lanes ? sum_w : sum_n;
        end else if (opc_is_bool(opcode)) begin
            nxt_res = bool_res;
        end else if (opc_is_cmp(opcode)) begin
            for (int k = 0; k < MASK_W; k++) begin
                nxt_mask[k] = (k < active) ? rel_mask[k] : 1'b0;
            end
        end
        if (single_w) begin
            nxt_res[DATA_W-1:HALF_W] = '0;
        end
    end

    // Output registers: load on issue, hold otherwise, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            cmp_mask  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result   <= nxt_res;
                cmp_mask <= nxt_mask;
            end
        end
    end

    // R2: valid strobe follows issue by one edge
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2: outputs hold while nothing is issued
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(cmp_mask)));
    // R3: a zero narrow lane 1 in both operands stays zero whatever lane 0 carries out
    a_r3_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == OPC_ADD && !wide_lanes
         && src_a[2*NARROW_W-1:NARROW_W] == '0 && src_b[2*NARROW_W-1:NARROW_W] == '0)
        |=> result[2*NARROW_W-1:NARROW_W] == '0);
    // R7: upper half of the result is cleared in single-width mode
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && single_w) |=> result[DATA_W-1:HALF_W] == '0);
    // R7: single-width compares set no bit for an upper-half lane
    a_r7_mask_low: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && single_w && opc_is_cmp(opcode))
        |=> cmp_mask[MASK_W-1:NARROW_HALF] == '0);
    // R8: non-compare operations leave the mask clear
    a_r8_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !opc_is_cmp(opcode)) |=> cmp_mask == '0);

endmodule

// File: tb/simd_fixed_alu_test.sv
module simd_fixed_alu_test;
    localparam int DW = 16;
    localparam int NW = 4;
    localparam int WW = 8;
    localparam int MW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [4:0]    opcode = '0;
    logic          wide_lanes = 1'b0;
    logic          single_w = 1'b0;
    logic [DW-1:0] src_a = '0;
    logic [DW-1:0] src_b = '0;
    logic          out_valid;
    logic [DW-1:0] result;
    logic [MW-1:0] cmp_mask;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    simd_fixed_alu #(.DATA_W(DW), .NARROW_W(NW), .WIDE_W(WW), .MASK_W(MW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .wide_lanes(wide_lanes), .single_w(single_w), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .result(result), .cmp_mask(cmp_mask)
    );

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Arithmetic reference model built from the requirements
    task automatic model(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [4:0] op,
                         input logic wide, input logic single,
                         output logic [DW-1:0] r, output logic [MW-1:0] m);
        int lw, nl, bits;
        longint full, al, bl, sa, sb, v;
        r = '0;
        m = '0;
        lw = wide ? WW : NW;
        nl = DW / lw;
        if (single) nl = nl / 2;
        bits = single ? DW / 2 : DW;
        full = longint'(1) << lw;
        if (op[4]) begin
            for (int i = 0; i < bits; i++) r[i] = op[{a[i], b[i]}];
        end else if (op == 5'b00000 || op == 5'b00001 || op[4:2] == 3'b001) begin
            for (int l = 0; l < nl; l++) begin
                al = longint'(a >> (l * lw)) & (full - 1);
                bl = longint'(b >> (l * lw)) & (full - 1);
                sa = (al >= full / 2) ? al - full : al;
                sb = (bl >= full / 2) ? bl - full : bl;
                case (op)
                    5'b00000: begin v = (al + bl) % full; r = r | (DW'(v) << (l * lw)); end
                    5'b00001: begin v = (al - bl + full) % full; r = r | (DW'(v) << (l * lw)); end
                    5'b00100: m[l] = (sa > sb);
                    5'b00101: m[l] = (sa <= sb);
                    5'b00110: m[l] = (sa != sb);
                    default:  m[l] = (sa == sb);
                endcase
            end
        end
    endtask

    task automatic check(input string req, input logic [DW-1:0] act_r, input logic [DW-1:0] exp_r,
                         input logic [MW-1:0] act_m, input logic [MW-1:0] exp_m,
                         input logic act_v, input logic exp_v);
        n_checks++;
        if (act_r !== exp_r || act_m !== exp_m || act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual result=%h mask=%h valid=%b expected result=%h mask=%h valid=%b",
                     req, act_r, act_m, act_v, exp_r, exp_m, exp_v);
        end
    endtask

    // Issue one operation at a falling edge and check it one rising edge later
    task automatic run(input string req, input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic [4:0] op, input logic wide, input logic single);
        logic [DW-1:0] er;
        logic [MW-1:0] em;
        model(a, b, op, wide, single, er, em);
        src_a = a; src_b = b; opcode = op; wide_lanes = wide; single_w = single;
        in_valid = 1'b1;
        @(negedge clk);
        check(req, result, er, cmp_mask, em, out_valid, 1'b1);
    endtask

    function automatic string arith_tag(input logic [4:0] op);
        if (op == 5'b00000) return "R3 add";
        if (op == 5'b00001) return "R4 sub";
        return "R6 compare";
    endfunction

    initial begin
        #1ms;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual run still active expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] hr;
        logic [MW-1:0] hm;
        logic [4:0] ops[6];
        ops = '{5'b00000, 5'b00001, 5'b00100, 5'b00101, 5'b00110, 5'b00111};

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset", result, '0, cmp_mask, '0, out_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle valid low", result, '0, cmp_mask, '0, out_valid, 1'b0);

        // R3: explicit carry cut, lane 0 overflows and lane 1 must stay zero
        run("R3 carry cut", 16'h000F, 16'h0001, 5'b00000, 1'b0, 1'b0);
        if (result !== 16'h0000) begin
            n_fail++;
            $display("FAIL R3 lane1: actual %h expected 0000", result);
        end
        n_checks++;
        // R4: explicit borrow cut
        run("R4 borrow cut", 16'h0000, 16'h0001, 5'b00001, 1'b0, 1'b0);
        if (result !== 16'h000F) begin
            n_fail++;
            $display("FAIL R4 lane1: actual %h expected 000f", result);
        end
        n_checks++;

        // R3 R4 R6 R7: exhaustive narrow lane pairs broadcast to all lanes
        for (int s = 0; s < 2; s++)
            for (int o = 0; o < 6; o++)
                for (int x = 0; x < 16; x++)
                    for (int y = 0; y < 16; y++)
                        run(s ? "R7 single narrow" : arith_tag(ops[o]),
                            {4{x[3:0]}}, {4{y[3:0]}}, ops[o], 1'b0, s[0]);

        // R3 R4 R6 R7: wide lanes and mixed narrow lanes, random operands
        for (int s = 0; s < 2; s++)
            for (int o = 0; o < 6; o++)
                for (int w = 0; w < 2; w++)
                    for (int k = 0; k < 150; k++) begin
                        seed = next_rand(seed);
                        run(s ? "R7 single" : arith_tag(ops[o]), seed[15:0], seed[31:16],
                            ops[o], w[0], s[0]);
                    end

        // R5: named logical functions against direct expressions
        src_a = 16'hC3A5; src_b = 16'h0FF0;
        run("R5 and", src_a, src_b, 5'b11000, 1'b0, 1'b0);
        check("R5 and expr", result, src_a & src_b, cmp_mask, '0, out_valid, 1'b1);
        run("R5 or", src_a, src_b, 5'b11110, 1'b0, 1'b0);
        check("R5 or expr", result, src_a | src_b, cmp_mask, '0, out_valid, 1'b1);
        run("R5 xor", src_a, src_b, 5'b10110, 1'b0, 1'b0);
        check("R5 xor expr", result, src_a ^ src_b, cmp_mask, '0, out_valid, 1'b1);
        run("R5 copy a", src_a, src_b, 5'b11100, 1'b0, 1'b0);
        check("R5 copy expr", result, src_a, cmp_mask, '0, out_valid, 1'b1);
        run("R5 ones", src_a, src_b, 5'b11111, 1'b0, 1'b0);
        check("R5 ones expr", result, 16'hFFFF, cmp_mask, '0, out_valid, 1'b1);

        // R5 R7 R8: all sixteen truth tables, random operands
        for (int s = 0; s < 2; s++)
            for (int t = 0; t < 16; t++)
                for (int k = 0; k < 32; k++) begin
                    seed = next_rand(seed);
                    run(s ? "R7 single logic" : "R5 R8 logic", seed[15:0], seed[31:16],
                        {1'b1, t[3:0]}, k[0], s[0]);
                end

        // R9: reserved opcodes give zeros
        for (int c = 2; c < 16; c++) begin
            if (c >= 4 && c < 8) continue;
            seed = next_rand(seed);
            run("R9 reserved", seed[15:0], seed[31:16], c[4:0], 1'b0, 1'b0);
        end

        // R2: hold while idle after an operation
        run("R2 issue", 16'h1234, 16'h1111, 5'b00000, 1'b0, 1'b0);
        hr = result; hm = cmp_mask;
        in_valid = 1'b0;
        src_a = 16'hFFFF; opcode = 5'b00100;
        @(negedge clk);
        check("R2 hold", result, hr, cmp_mask, hm, out_valid, 1'b0);
        @(negedge clk);
        check("R2 hold 2", result, hr, cmp_mask, hm, out_valid, 1'b0);

        // R1: reset after activity clears state
        run("R6 before reset", 16'h0000, 16'h0000, 5'b00111, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset after use", result, '0, cmp_mask, '0, out_valid, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule